// File: doc/BRIEF.md
# Keyed Window Watchdog Timer

This block is a watchdog timer that runs from a single source clock, which is also the clock of its register bus. A clock-enable chain of two stages, a selectable pre-divider and then a prescaler, turns the source clock into a counter tick. An 8-bit up counter advances on each tick. If software fails to service it, the counter overflows and the block raises its watchdog event.

Software services the watchdog by writing an ordered pair of key bytes. A window threshold rejects a service that comes too early: if the counter has not yet reached the threshold when the pair completes, the event fires at once. Every write to the control register must also carry a fixed check code, or the event fires immediately. The event produces a fixed-length low pulse on one of two outputs, either an interrupt line or a reset line, as chosen by a mode bit. A lock bit can freeze the disable control until the next system reset.

There are two reset inputs. The system reset restores the lock bit, the mode bit and the pulse generator. The I/O reset restores the counter, both dividers, the key sequencer, the control register and the window register.

Top module: `wdog_keyed`

## Requirements
- R1: The counter is read at address 1, bits 7:0 (upper bits read 0). It rises by exactly one on each divider tick and wraps from 255 to 0.
- R2: Control bits 11:8 select the pre-divider. Codes 0 to 3 divide by 512, 1024, 2048 and 4096. Codes 8 to 15 divide by 2, 4, 8, 16, 32, 64, 128 and 256. Codes 4 to 7 divide by 512.
- R3: Control bits 2:0 select the prescaler. Codes 0 and 1 divide by 1, and code n from 2 to 7 divides by 2^(n-1). One counter tick spans pre-divider × prescaler source cycles.
- R4: A tick that takes the counter from 255 to 0 fires the watchdog event.
- R5: The key register is at address 2 and takes bits 7:0. A write of 0x55 arms the sequencer, and a further 0x55 keeps it armed. A write of 0xAA while armed clears the counter to 0 and disarms the sequencer. Any other value disarms it. A write of 0xAA while disarmed has no effect.
- R6: The window register is at address 4, bits 7:0, with reset value 0. A completed key sequence while the counter is below the window value fires the event.
- R7: The control register is at address 3. A write whose bits 5:3 are not binary 101 fires the event and leaves the control register unchanged. A write with 101 updates it.
- R8: Status bit 1 (address 0) is the mode, reset value 0. A value of 1 sends events to the interrupt output `int_n`. A value of 0 sends them to the reset output `rst_out_n`.
- R9: An event starts a low pulse of exactly 512 source cycles on the selected output. Events during a pulse are ignored. The two outputs are never low together. Status bit 2 reads the level of `int_n`.
- R10: Control bit 6 is the disable bit, reset value 0. While it is set, the counter and both dividers are held at 0 and no event fires.
- R11: Status bit 0 is the lock bit, reset value 1. Writing 1 to it clears it. Writing 0 has no effect. While it is 0, control writes leave the disable bit unchanged. Only the system reset sets it again.
- R12: Reads of the key register return the control image: pre-divider in bits 11:8, disable in bit 6, prescaler in bits 2:0, and 0 in all other bits.
- R13: After reset, status reads 0x0005 and the counter, control and window registers read 0. The I/O reset leaves lock and mode untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the bus clock |
| sys_rst_n | input | 1 | Active-low system reset (lock, mode, pulse) |
| io_rst_n | input | 1 | Active-low I/O reset (counter, dividers, key, control, window) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| int_n | output | 1 | Active-low watchdog interrupt pulse |
| rst_out_n | output | 1 | Active-low watchdog reset pulse |

## Verification
The bench targets the edges of the key sequence: a stray byte between 0x55 and 0xAA, a repeated 0x55, and a lone 0xAA. A sequencer that failed to disarm or re-arm correctly would clear the counter when it should not, or miss a clear it should make. It services the counter just below and just above the window threshold, and writes control words with a wrong check code both while enabled and while disabled. A design that applied the bad word, or fired while disabled, would show a wrong control read-back or a spurious pulse. It measures the pulse length, sends a second event in the middle of a pulse, sweeps the divider codes including a reserved one, and tries to disable the watchdog after the lock has been taken, then after an I/O reset alone.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam logic [2:0] ADDR_STATUS = 3'd0;
  localparam logic [2:0] ADDR_COUNT  = 3'd1;
  localparam logic [2:0] ADDR_KEY    = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_WINDOW = 3'd4;

  localparam logic [2:0] CHECK_CODE = 3'b101;
  localparam logic [7:0] KEY_ARM    = 8'h55;
  localparam logic [7:0] KEY_FIRE   = 8'hAA;

  localparam int PREDIV_MAX = 4096;
  localparam int PRESC_MAX  = 64;

  typedef struct packed {
    logic [3:0] prediv;
    logic       dis;
    logic [2:0] presc;
  } ctrl_t;

  // source cycles per pre-divider step for a given code
  function automatic int unsigned prediv_ratio(input logic [3:0] code);
    if (code[3])      return 32'd2 << code[2:0];
    else if (code[2]) return 32'd512;
    else              return 32'd512 << code[1:0];
  endfunction

  // pre-divider steps per counter tick for a given code
  function automatic int unsigned presc_ratio(input logic [2:0] code);
    if (code <= 3'd1) return 32'd1;
    else              return 32'd1 << (code - 3'd1);
  endfunction

endpackage

// File: rtl/wdk_divider.sv
module wdk_divider import wdk_pkg::*; #(
  parameter int PRE_W = 12,
  parameter int PS_W  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] prediv_code,
  input  logic [2:0] presc_code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [PS_W-1:0]  ps_q, ps_lim;
  logic             pre_tick;

  assign pre_lim  = PRE_W'(prediv_ratio(prediv_code) - 32'd1);
  assign ps_lim   = PS_W'(presc_ratio(presc_code) - 32'd1);
  assign pre_tick = en && (pre_q >= pre_lim);
  assign tick     = pre_tick && (ps_q >= ps_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ps_q  <= '0;
    end else if (!en) begin
      pre_q <= '0;
      ps_q  <= '0;
    end else if (pre_tick) begin
      pre_q <= '0;
      ps_q  <= tick ? '0 : ps_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq import wdk_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  output logic       done
);
  logic armed_q;

  assign done = key_wr && armed_q && (key_val == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (key_wr) armed_q <= (key_val == KEY_ARM);
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             overflow
);
  assign overflow = en && tick && !clear && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic to_int,
  output logic busy,
  output logic int_n,
  output logic rst_out_n
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;
  logic          int_sel_q;

  assign busy      = (left_q != '0);
  assign int_n     = !(busy && int_sel_q);
  assign rst_out_n = !(busy && !int_sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      int_sel_q <= 1'b0;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end else if (fire) begin
      left_q    <= PW'(PULSE_LEN);
      int_sel_q <= to_int;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed import wdk_pkg::*; #(
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int PULSE_LEN = 512
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              io_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              int_n,
  output logic              rst_out_n
);
  localparam int PRE_W = $clog2(PREDIV_MAX);
  localparam int PS_W  = $clog2(PRESC_MAX);

  // named internal events, observed by the bound checker
  logic wr_status, wr_key, wr_ctrl, wr_window;
  logic chk_ok, en, tick, key_done, overflow, early, bad_chk, fire, busy;
  logic lock_q, mode_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] win_q, cnt;
  logic [15:0]      ctrl_img;
  logic             unused_wbits;

  assign wr_status = wr_en && (addr == ADDR_W'(ADDR_STATUS));
  assign wr_key    = wr_en && (addr == ADDR_W'(ADDR_KEY));
  assign wr_ctrl   = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign wr_window = wr_en && (addr == ADDR_W'(ADDR_WINDOW));
  assign chk_ok    = (wdata[5:3] == CHECK_CODE);
  assign unused_wbits = ^{wdata[DATA_W-1:12], wdata[7]};

  assign en      = !ctrl_q.dis;
  assign early   = en && key_done && (cnt < win_q);
  assign bad_chk = en && wr_ctrl && !chk_ok;
  assign fire    = overflow || early || bad_chk;

  // system-reset domain: lock and mode
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      lock_q <= 1'b1;
      mode_q <= 1'b0;
    end else if (wr_status) begin
      if (wdata[0]) lock_q <= 1'b0;
      mode_q <= wdata[1];
    end
  end

  // I/O-reset domain: control and window
  always_ff @(posedge clk or negedge io_rst_n) begin
    if (!io_rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else begin
      if (wr_ctrl && chk_ok) begin
        ctrl_q.prediv <= wdata[11:8];
        ctrl_q.presc  <= wdata[2:0];
        if (lock_q) ctrl_q.dis <= wdata[6];
      end
      if (wr_window) win_q <= wdata[CNT_W-1:0];
    end
  end

  wdk_divider #(.PRE_W(PRE_W), .PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(io_rst_n), .en(en),
    .prediv_code(ctrl_q.prediv), .presc_code(ctrl_q.presc), .tick(tick)
  );

  wdk_keyseq u_key (
    .clk(clk), .rst_n(io_rst_n), .key_wr(wr_key),
    .key_val(wdata[7:0]), .done(key_done)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(io_rst_n), .en(en), .tick(tick),
    .clear(key_done), .cnt(cnt), .overflow(overflow)
  );

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(sys_rst_n), .fire(fire), .to_int(mode_q),
    .busy(busy), .int_n(int_n), .rst_out_n(rst_out_n)
  );

  assign ctrl_img = {4'b0, ctrl_q.prediv, 1'b0, ctrl_q.dis, 3'b0, ctrl_q.presc};

  always_comb begin
    case (addr)
      ADDR_W'(ADDR_STATUS): rdata = DATA_W'({int_n, mode_q, lock_q});
      ADDR_W'(ADDR_COUNT):  rdata = DATA_W'(cnt);
      ADDR_W'(ADDR_KEY),
      ADDR_W'(ADDR_CTRL):   rdata = DATA_W'(ctrl_img);
      ADDR_W'(ADDR_WINDOW): rdata = DATA_W'(win_q);
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512
) (
  input logic             clk,
  input logic             sys_rst_n,
  input logic             io_rst_n,
  input logic             int_n,
  input logic             rst_out_n,
  input logic             en,
  input logic             tick,
  input logic             key_done,
  input logic             bad_chk,
  input logic             fire,
  input logic             busy,
  input logic             dis_q,
  input logic             lock_q,
  input logic [CNT_W-1:0] cnt
);
  logic        low_now;
  logic [15:0] low_run;

  assign low_now = !int_n || !rst_out_n;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   low_run <= '0;
    else if (low_now) low_run <= low_run + 16'd1;
    else              low_run <= '0;
  end

  a_r9_outputs_exclusive: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(!int_n && !rst_out_n));

  a_r9_pulse_not_long: assert property (@(posedge clk) disable iff (!sys_rst_n)
    low_run <= 16'(PULSE_LEN));

  a_r9_pulse_full_len: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ($past(low_now) && !low_now) |-> (low_run == 16'(PULSE_LEN)));

  a_r9_fire_starts_pulse: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (fire && !busy) |=> busy);

  a_r4_overflow_fires: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    (en && tick && !key_done && cnt == {CNT_W{1'b1}}) |-> fire);

  a_r1_increment: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    (en && tick && !key_done) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r5_key_clears: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    key_done |=> (cnt == '0));

  a_r7_badchk_fires: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    bad_chk |-> fire);

  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    dis_q |=> (cnt == '0));

  a_r10_no_fire_disabled: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    !en |-> !fire);

  a_r11_lock_freezes: assert property (@(posedge clk) disable iff (!sys_rst_n || !io_rst_n)
    !lock_q |=> $stable(dis_q));
endmodule

bind wdog_keyed wdk_checker #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .io_rst_n(io_rst_n),
  .int_n(int_n), .rst_out_n(rst_out_n), .en(en), .tick(tick),
  .key_done(key_done), .bad_chk(bad_chk), .fire(fire), .busy(busy),
  .dis_q(ctrl_q.dis), .lock_q(lock_q), .cnt(cnt)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
  localparam int PULSE = 512;

  logic        clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        io_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        int_n, rst_out_n;

  int    n_cmp = 0, n_bad = 0;
  bit    run = 0, finished = 0;
  string cur_tag = "R13";

  wdog_keyed dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .io_rst_n(io_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .int_n(int_n), .rst_out_n(rst_out_n)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_pre = 0, m_ps = 0, m_cnt = 0, m_win = 0, m_pdiv = 0, m_psc = 0, m_left = 0;
  bit m_dis = 0, m_arm = 0, m_lock = 1, m_mode = 0, m_pmode = 0;

  function automatic int pre_len(int c);
    if (c >= 8) return 2 ** (c - 7);
    if (c < 4)  return 512 * (2 ** c);
    return 512;
  endfunction

  function automatic int ps_len(int c);
    return (c < 2) ? 1 : 2 ** (c - 1);
  endfunction

  function automatic bit m_int_n();   return !(m_left > 0 && m_pmode);  endfunction
  function automatic bit m_rst_n();   return !(m_left > 0 && !m_pmode); endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0:       return {13'd0, m_int_n(), m_mode, m_lock};
      3'd1:       return 16'(m_cnt);
      3'd2, 3'd3: return 16'((m_pdiv << 8) | (int'(m_dis) << 6) | m_psc);
      3'd4:       return 16'(m_win);
      default:    return 16'd0;
    endcase
  endfunction

  always @(negedge sys_rst_n) begin
    m_lock = 1; m_mode = 0; m_left = 0; m_pmode = 0;
  end

  always @(negedge io_rst_n) begin
    m_pre = 0; m_ps = 0; m_cnt = 0; m_arm = 0; m_pdiv = 0; m_psc = 0; m_dis = 0; m_win = 0;
  end

  always @(posedge clk) begin
    bit en, pt, tk, done, ovf, early, bad, fire, old_lock;
    en       = !m_dis;
    old_lock = m_lock;
    pt    = en && (m_pre >= pre_len(m_pdiv) - 1);
    tk    = pt && (m_ps >= ps_len(m_psc) - 1);
    done  = wr_en && addr == 3'd2 && wdata[7:0] == 8'hAA && m_arm;
    ovf   = en && tk && m_cnt == 255 && !done;
    early = en && done && m_cnt < m_win;
    bad   = en && wr_en && addr == 3'd3 && wdata[5:3] != 3'b101;
    fire  = ovf || early || bad;
    if (sys_rst_n) begin
      if (m_left > 0) m_left--;
      else if (fire) begin m_left = PULSE; m_pmode = m_mode; end
      if (wr_en && addr == 3'd0) begin
        if (wdata[0]) m_lock = 0;
        m_mode = wdata[1];
      end
    end
    if (io_rst_n) begin
      if (!en) begin
        m_pre = 0; m_ps = 0; m_cnt = 0;
      end else begin
        if (pt) begin m_pre = 0; m_ps = tk ? 0 : m_ps + 1; end
        else m_pre++;
        if (done) m_cnt = 0;
        else if (tk) m_cnt = (m_cnt + 1) % 256;
      end
      if (wr_en && addr == 3'd2) m_arm = (wdata[7:0] == 8'h55);
      if (wr_en && addr == 3'd3 && wdata[5:3] == 3'b101) begin
        m_pdiv = wdata[11:8];
        m_psc  = wdata[2:0];
        if (old_lock) m_dis = wdata[6];
      end
      if (wr_en && addr == 3'd4) m_win = wdata[7:0];
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run && sys_rst_n && io_rst_n) begin
      check(int_n === m_int_n(), cur_tag, "int_n vs model", 32'(int_n), 32'(m_int_n()));
      check(rst_out_n === m_rst_n(), cur_tag, "rst_out_n vs model", 32'(rst_out_n), 32'(m_rst_n()));
      check(rdata === m_read(addr), cur_tag, "rdata vs model", 32'(rdata), 32'(m_read(addr)));
    end
  end

  // ---------------- stimulus helpers (entered at posedge+1) ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    check(rdata === exp, tag, "register read", 32'(rdata), 32'(exp));
    step();
  endtask

  task automatic serve();
    bus_wr(3'd2, 16'h0055);
    bus_wr(3'd2, 16'h00AA);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int dur;
    idle(5);
    sys_rst_n = 1'b1; io_rst_n = 1'b1;
    step();
    run = 1;

    // R13: reset values
    cur_tag = "R13";
    rd_chk(3'd0, 16'h0005, "R13");
    rd_chk(3'd3, 16'h0000, "R13");
    rd_chk(3'd4, 16'h0000, "R13");
    rd_chk(3'd1, 16'h0000, "R13");

    // R11: writing 0 to the lock bit has no effect
    cur_tag = "R11";
    bus_wr(3'd0, 16'h0000);
    rd_chk(3'd0, 16'h0005, "R11");

    // R2/R1: fastest pre-divider, counter runs
    cur_tag = "R2";
    bus_wr(3'd3, 16'h0828);
    addr = 3'd1; cur_tag = "R1";
    idle(40);

    // R5: key sequence variants
    cur_tag = "R5";
    serve();
    rd_chk(3'd1, 16'h0000, "R5");
    idle(20);
    bus_wr(3'd2, 16'h0055); bus_wr(3'd2, 16'h0012); bus_wr(3'd2, 16'h00AA);
    addr = 3'd1; idle(6);
    bus_wr(3'd2, 16'h0055); bus_wr(3'd2, 16'h0055); bus_wr(3'd2, 16'h00AA);
    rd_chk(3'd1, 16'h0000, "R5");
    idle(10);
    bus_wr(3'd2, 16'h00AA);
    addr = 3'd1; idle(4);

    // R12: key register reads the control image
    rd_chk(3'd2, 16'h0800, "R12");

    // R6: early service fires a reset pulse (mode 0)
    cur_tag = "R6";
    serve();
    bus_wr(3'd4, 16'h0064);
    rd_chk(3'd4, 16'h0064, "R6");
    serve();
    @(negedge clk);
    check(rst_out_n === 1'b0 && int_n === 1'b1, "R6", "early service pulse", 32'({rst_out_n, int_n}), 32'h1);
    step();
    bus_wr(3'd4, 16'h0000);
    cur_tag = "R9";
    idle(200); serve(); idle(200); serve(); idle(130);
    // service after the window threshold: no event
    cur_tag = "R6";
    bus_wr(3'd4, 16'h000A);
    serve(); idle(40); serve();
    @(negedge clk);
    check(rst_out_n === 1'b1 && int_n === 1'b1, "R6", "late service quiet", 32'({rst_out_n, int_n}), 32'h3);
    step();
    bus_wr(3'd4, 16'h0000);

    // R8/R4/R9: interrupt mode, natural overflow, pulse length
    cur_tag = "R8";
    bus_wr(3'd3, 16'h0928);
    bus_wr(3'd0, 16'h0002);
    rd_chk(3'd0, 16'h0007, "R8");
    cur_tag = "R4";
    serve();
    addr = 3'd0;
    @(negedge clk);
    for (int i = 0; i < 1200 && int_n; i++) @(negedge clk);
    check(int_n === 1'b0 && rst_out_n === 1'b1, "R4", "overflow interrupt", 32'({int_n, rst_out_n}), 32'h1);
    check(rdata === 16'h0003, "R9", "status shows int line", 32'(rdata), 32'h3);
    dur = 0;
    while (int_n === 1'b0 && dur < 2000) begin dur++; @(negedge clk); end
    check(dur == PULSE, "R9", "pulse length", 32'(dur), 32'(PULSE));
    step();
    serve();

    // R7: bad check code fires and is not applied; second event in pulse ignored
    cur_tag = "R7";
    bus_wr(3'd3, 16'h0200);
    rd_chk(3'd3, 16'h0900, "R7");
    cur_tag = "R9";
    bus_wr(3'd3, 16'h0B00);
    idle(250); serve(); idle(280); serve();

    // R3/R2: prescaler codes and a reserved pre-divider code
    cur_tag = "R3";
    bus_wr(3'd3, 16'h092B);
    addr = 3'd1; idle(200); serve();
    bus_wr(3'd3, 16'h0829);
    addr = 3'd1; idle(60); serve();
    cur_tag = "R2";
    bus_wr(3'd3, 16'h0528);
    addr = 3'd1; idle(1100); serve();
    bus_wr(3'd3, 16'h0828);

    // R10: disable holds everything at zero, no event
    cur_tag = "R10";
    bus_wr(3'd3, 16'h0868);
    idle(3);
    rd_chk(3'd1, 16'h0000, "R10");
    bus_wr(3'd3, 16'h0840);
    @(negedge clk);
    check(int_n === 1'b1 && rst_out_n === 1'b1, "R10", "no event while disabled", 32'({int_n, rst_out_n}), 32'h3);
    step();
    rd_chk(3'd3, 16'h0840, "R10");
    addr = 3'd1; idle(20);
    bus_wr(3'd3, 16'h0828);
    serve();

    // R11: lock freezes the disable bit
    cur_tag = "R11";
    bus_wr(3'd0, 16'h0003);
    rd_chk(3'd0, 16'h0006, "R11");
    bus_wr(3'd3, 16'h0868);
    rd_chk(3'd3, 16'h0800, "R11");
    serve();

    // R13: I/O reset alone keeps lock and mode
    cur_tag = "R13";
    io_rst_n = 1'b0; idle(3); io_rst_n = 1'b1; step();
    rd_chk(3'd0, 16'h0006, "R13");
    rd_chk(3'd3, 16'h0000, "R13");
    idle(5);

    finished = 1;
    summary();
    $finish;
  end
endmodule